// File: doc/BRIEF.md
# Register Rename Map with Rollback History

This block keeps the mapping from architectural registers to physical registers for an out-of-order core. It also keeps a per-register ready bit and a pool of unused physical registers. Every destination rename takes the lowest-numbered free physical register and updates the map. It also pushes a record onto a circular history ring. The record holds the instruction's sequence number, the architectural register, the newly taken physical register and the one it replaced.

The history ring is unwound from either end.

- **Squash.** A squash with sequence number S removes records from the newest end while their sequence number is greater than S. Each removed record puts its replaced physical register back into the map and returns its newly taken register to the pool.
- **Commit.** A commit with sequence number C retires records from the oldest end while their sequence number is at most C. Each retired record returns only the replaced register.

Both walks handle one record per cycle and hold `busy` high until they stop. Each returned register is shown on the release outputs in the cycle it is freed. Renames are held off while a walk runs, while a squash is requested, and when no physical register or history slot is left.

Source operands are looked up combinationally. A lookup returns the mapped physical register and its ready bit. The ready bit is set by a writeback input and cleared when the register is handed out by a rename.

Top module: `rename_rollback_unit`

## Requirements
- R1: After synchronous reset, architectural register i maps to physical register i and every ready bit is 1. Physical registers NUM_ARCH to NUM_PHYS-1 are free, the history ring is empty and `busy` is 0.
- R2: `src_phys` shows the current mapping of `src_arch` and `src_ready` shows that register's ready bit, both combinationally. A cycle with `wb_valid` high sets the ready bit of `wb_phys` at the next edge.
- R3: An accepted rename with `ren_has_dst` high does four things:
  - it shows the lowest-numbered free physical register on `ren_phys`;
  - it shows the current mapping of `ren_arch` on `ren_prev`;
  - at the edge, it maps `ren_arch` to `ren_phys`;
  - at the edge, it clears the ready bit of `ren_phys`.
- R4: `ren_stall` is 1 for a valid rename when any of these holds, and a stalled rename changes no state:
  - `busy` is 1;
  - `sq_valid` is 1;
  - it has a destination and the free pool is empty;
  - it has a destination and the history ring is full.
- R5: After a cycle with `sq_valid` high, records are removed newest first, one per cycle, while their sequence number is greater than `sq_seq`. Each removal restores the record's architectural register to its replaced physical register and shows the newly taken register on `rel_phys` with `rel_valid` high.
- R6: After a cycle with `cm_valid` high, records are retired oldest first, one per cycle, while their sequence number is at most `cm_seq`. Each retirement shows the replaced physical register on `rel_phys` with `rel_valid` high and leaves the map unchanged.
- R7: A commit releases nothing when the history ring is empty, or when the oldest record's sequence number is already greater than `cm_seq`.
- R8: A commit presented in the same cycle as a squash, or while `busy` is 1, is dropped and retires nothing.
- R9: `busy` rises in the cycle after a squash or commit request. It stays high for one cycle per record removed plus one final cycle with `rel_valid` low, then falls. `rel_valid` is never high while `busy` is low.
- R10: A valid rename with `ren_has_dst` low consumes no physical register and adds no history record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_arch | input | ARCH_W | Architectural source register to look up |
| src_phys | output | PHYS_W | Physical register currently mapped to `src_arch` |
| src_ready | output | 1 | Ready bit of `src_phys` |
| wb_valid | input | 1 | Marks `wb_phys` as ready |
| wb_phys | input | PHYS_W | Physical register whose value was produced |
| ren_valid | input | 1 | Rename request present |
| ren_has_dst | input | 1 | The request has a destination register |
| ren_arch | input | ARCH_W | Architectural destination register |
| ren_seq | input | SEQ_W | Sequence number of the renamed instruction |
| ren_stall | output | 1 | Request not accepted this cycle |
| ren_phys | output | PHYS_W | Physical register handed out |
| ren_prev | output | PHYS_W | Physical register being replaced |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Keep records with sequence number up to this value |
| cm_valid | input | 1 | Commit request |
| cm_seq | input | SEQ_W | Retire records with sequence number up to this value |
| busy | output | 1 | A squash or commit walk is in progress |
| rel_valid | output | 1 | A physical register is returned this cycle |
| rel_phys | output | PHYS_W | The returned physical register |

## Verification
The bench uses the package values: eight architectural registers, sixteen physical registers, an eight-record history ring and 8-bit sequence numbers. This leaves exactly eight spare physical registers. Eight back-to-back renames therefore empty the free pool and fill the ring together, and a ninth rename must stall. A squash to sequence number 0 then unwinds the full ring depth in reverse allocation order. The small register count also makes the lowest-free allocation order easy to predict after partial squashes and commits.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int NUM_ARCH   = 8;
    localparam int NUM_PHYS   = 16;
    localparam int HIST_DEPTH = 8;
    localparam int SEQ_W      = 8;

    localparam int ARCH_W = $clog2(NUM_ARCH);
    localparam int PHYS_W = $clog2(NUM_PHYS);
    localparam int HIST_W = $clog2(HIST_DEPTH);
    localparam int CNT_W  = $clog2(HIST_DEPTH + 1);

    typedef logic [ARCH_W-1:0] arch_t;
    typedef logic [PHYS_W-1:0] phys_t;
    typedef logic [SEQ_W-1:0]  seq_t;

    typedef struct packed {
        seq_t  seq;
        arch_t arch;
        phys_t fresh;
        phys_t prior;
    } hist_rec_t;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_SQUASH,
        WALK_COMMIT
    } walk_e;
endpackage

// File: rtl/rr_free_pool.sv
module rr_free_pool
    import rr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_en,
    output phys_t take_idx,
    output logic  any_free,
    input  logic  give_en,
    input  phys_t give_idx
);
    logic [NUM_PHYS-1:0] free_q;

    always_comb begin
        take_idx = '0;
        for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (free_q[i]) take_idx = PHYS_W'(i);
        end
    end

    assign any_free = |free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PHYS; i++) free_q[i] <= (i >= NUM_ARCH);
        end else begin
            if (take_en) free_q[take_idx] <= 1'b0;
            if (give_en) free_q[give_idx] <= 1'b1;
        end
    end

    assert_no_double_release_R5: assert property (@(posedge clk) disable iff (rst)
        give_en |-> !free_q[give_idx]);

    assert_no_take_during_walk_R9: assert property (@(posedge clk) disable iff (rst)
        !(take_en && give_en));
endmodule

// File: rtl/rr_hist_ring.sv
module rr_hist_ring
    import rr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       push_en,
    input  hist_rec_t  push_rec,
    input  logic       drop_new_en,
    input  logic       drop_old_en,
    output hist_rec_t  newest,
    output hist_rec_t  oldest,
    output logic       full,
    output logic       empty
);
    hist_rec_t          ring_q [HIST_DEPTH];
    logic [HIST_W-1:0]  head_q;
    logic [HIST_W-1:0]  tail_q;
    logic [CNT_W-1:0]   count_q;

    function automatic logic [HIST_W-1:0] fwd(input logic [HIST_W-1:0] p);
        return (p == HIST_W'(HIST_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [HIST_W-1:0] back(input logic [HIST_W-1:0] p);
        return (p == '0) ? HIST_W'(HIST_DEPTH - 1) : p - 1'b1;
    endfunction

    assign newest = ring_q[back(head_q)];
    assign oldest = ring_q[tail_q];
    assign full   = (count_q == CNT_W'(HIST_DEPTH));
    assign empty  = (count_q == '0);

    always_ff @(posedge clk) begin
        if (push_en) ring_q[head_q] <= push_rec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push_en)          head_q <= fwd(head_q);
            else if (drop_new_en) head_q <= back(head_q);
            if (drop_old_en)      tail_q <= fwd(tail_q);
            count_q <= count_q + CNT_W'(push_en) - CNT_W'(drop_new_en) - CNT_W'(drop_old_en);
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        push_en |-> (count_q != CNT_W'(HIST_DEPTH)));

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        (drop_new_en || drop_old_en) |-> (count_q != '0));

    assert_single_end_R9: assert property (@(posedge clk) disable iff (rst)
        $countones({push_en, drop_new_en, drop_old_en}) <= 1);
endmodule

// File: rtl/rr_map_sb.sv
module rr_map_sb
    import rr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  arch_t look_arch,
    output phys_t look_phys,
    output logic  look_ready,
    input  arch_t cur_arch,
    output phys_t cur_phys,
    input  logic  wr_en,
    input  arch_t wr_arch,
    input  phys_t wr_phys,
    input  logic  set_en,
    input  phys_t set_idx,
    input  logic  clr_en,
    input  phys_t clr_idx
);
    phys_t               map_q [NUM_ARCH];
    logic [NUM_PHYS-1:0] ready_q;

    assign look_phys  = map_q[look_arch];
    assign look_ready = ready_q[look_phys];
    assign cur_phys   = map_q[cur_arch];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PHYS_W'(i);
            ready_q <= '1;
        end else begin
            if (wr_en)  map_q[wr_arch]   <= wr_phys;
            if (set_en) ready_q[set_idx] <= 1'b1;
            if (clr_en) ready_q[clr_idx] <= 1'b0;
        end
    end

    assert_ready_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !ready_q[$past(clr_idx)]);

    assert_map_written_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (map_q[$past(wr_arch)] == $past(wr_phys)));
endmodule

// File: rtl/rename_rollback_unit.sv
module rename_rollback_unit
    import rr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ARCH_W-1:0] src_arch,
    output logic [PHYS_W-1:0] src_phys,
    output logic              src_ready,
    input  logic              wb_valid,
    input  logic [PHYS_W-1:0] wb_phys,
    input  logic              ren_valid,
    input  logic              ren_has_dst,
    input  logic [ARCH_W-1:0] ren_arch,
    input  logic [SEQ_W-1:0]  ren_seq,
    output logic              ren_stall,
    output logic [PHYS_W-1:0] ren_phys,
    output logic [PHYS_W-1:0] ren_prev,
    input  logic              sq_valid,
    input  logic [SEQ_W-1:0]  sq_seq,
    input  logic              cm_valid,
    input  logic [SEQ_W-1:0]  cm_seq,
    output logic              busy,
    output logic              rel_valid,
    output logic [PHYS_W-1:0] rel_phys
);
    walk_e     state_q;
    seq_t      target_q;
    hist_rec_t newest, oldest, push_rec;
    logic      ring_full, ring_empty, any_free;
    logic      do_rename, pop_new, pop_old, short_of_res;
    phys_t     take_idx, cur_phys;

    assign busy         = (state_q != WALK_IDLE);
    assign short_of_res = ren_has_dst && (!any_free || ring_full);
    assign ren_stall    = ren_valid && (busy || sq_valid || short_of_res);
    assign do_rename    = ren_valid && ren_has_dst && !ren_stall;
    assign ren_phys     = take_idx;
    assign ren_prev     = cur_phys;

    assign pop_new   = (state_q == WALK_SQUASH) && !ring_empty && (newest.seq > target_q);
    assign pop_old   = (state_q == WALK_COMMIT) && !ring_empty && (oldest.seq <= target_q);
    assign rel_valid = pop_new || pop_old;
    assign rel_phys  = pop_new ? newest.fresh : oldest.prior;

    assign push_rec = '{seq: ren_seq, arch: ren_arch, fresh: take_idx, prior: cur_phys};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= WALK_IDLE;
            target_q <= '0;
        end else if (sq_valid) begin
            state_q  <= WALK_SQUASH;
            target_q <= sq_seq;
        end else begin
            case (state_q)
                WALK_IDLE: begin
                    if (cm_valid) begin
                        state_q  <= WALK_COMMIT;
                        target_q <= cm_seq;
                    end
                end
                WALK_SQUASH: if (!pop_new) state_q <= WALK_IDLE;
                WALK_COMMIT: if (!pop_old) state_q <= WALK_IDLE;
                default:     state_q <= WALK_IDLE;
            endcase
        end
    end

    rr_free_pool u_pool (
        .clk      (clk),
        .rst      (rst),
        .take_en  (do_rename),
        .take_idx (take_idx),
        .any_free (any_free),
        .give_en  (rel_valid),
        .give_idx (rel_phys)
    );

    rr_hist_ring u_ring (
        .clk         (clk),
        .rst         (rst),
        .push_en     (do_rename),
        .push_rec    (push_rec),
        .drop_new_en (pop_new),
        .drop_old_en (pop_old),
        .newest      (newest),
        .oldest      (oldest),
        .full        (ring_full),
        .empty       (ring_empty)
    );

    rr_map_sb u_map (
        .clk        (clk),
        .rst        (rst),
        .look_arch  (src_arch),
        .look_phys  (src_phys),
        .look_ready (src_ready),
        .cur_arch   (ren_arch),
        .cur_phys   (cur_phys),
        .wr_en      (do_rename || pop_new),
        .wr_arch    (pop_new ? newest.arch : ren_arch),
        .wr_phys    (pop_new ? newest.prior : take_idx),
        .set_en     (wb_valid),
        .set_idx    (wb_phys),
        .clr_en     (do_rename),
        .clr_idx    (take_idx)
    );

    assert_squash_starts_walk_R5: assert property (@(posedge clk) disable iff (rst)
        sq_valid |=> (busy && state_q == WALK_SQUASH));

    assert_release_needs_busy_R9: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> busy);

    assert_busy_holds_rename_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && ren_valid) |-> ren_stall);

    assert_commit_dropped_by_squash_R8: assert property (@(posedge clk) disable iff (rst)
        (sq_valid && cm_valid) |=> !pop_old);
endmodule

// File: tb/tb_rename_rollback_unit.sv
module tb_rename_rollback_unit;
    import rr_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic [ARCH_W-1:0] src_arch;
    logic [PHYS_W-1:0] src_phys;
    logic              src_ready;
    logic              wb_valid;
    logic [PHYS_W-1:0] wb_phys;
    logic              ren_valid, ren_has_dst;
    logic [ARCH_W-1:0] ren_arch;
    logic [SEQ_W-1:0]  ren_seq;
    logic              ren_stall;
    logic [PHYS_W-1:0] ren_phys, ren_prev;
    logic              sq_valid, cm_valid;
    logic [SEQ_W-1:0]  sq_seq, cm_seq;
    logic              busy, rel_valid;
    logic [PHYS_W-1:0] rel_phys;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int exp_rel[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rename_rollback_unit dut (
        .clk(clk), .rst(rst),
        .src_arch(src_arch), .src_phys(src_phys), .src_ready(src_ready),
        .wb_valid(wb_valid), .wb_phys(wb_phys),
        .ren_valid(ren_valid), .ren_has_dst(ren_has_dst), .ren_arch(ren_arch),
        .ren_seq(ren_seq), .ren_stall(ren_stall), .ren_phys(ren_phys), .ren_prev(ren_prev),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .cm_valid(cm_valid), .cm_seq(cm_seq),
        .busy(busy), .rel_valid(rel_valid), .rel_phys(rel_phys)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic look(string req, int arch, int exp_phys, int exp_rdy);
        src_arch = ARCH_W'(arch);
        #1;
        check(req, $sformatf("map of arch %0d", arch), int'(src_phys), exp_phys);
        check(req, $sformatf("ready of arch %0d", arch), int'(src_ready), exp_rdy);
    endtask

    task automatic rename_one(string req, int arch, int seq, int exp_phys, int exp_prev);
        ren_valid = 1'b1; ren_has_dst = 1'b1;
        ren_arch = ARCH_W'(arch); ren_seq = SEQ_W'(seq);
        #1;
        check(req, "rename stall", int'(ren_stall), 0);
        check(req, "rename new phys", int'(ren_phys), exp_phys);
        check(req, "rename prev phys", int'(ren_prev), exp_prev);
        @(negedge clk);
        ren_valid = 1'b0;
        #1;
    endtask

    // Request already driven; checks busy and releases cycle by cycle.
    task automatic run_walk(string req);
        @(negedge clk);
        sq_valid = 1'b0; cm_valid = 1'b0;
        ren_valid = 1'b1; ren_has_dst = 1'b1; ren_arch = '0;
        #1;
        check("R4", "rename stall while busy", int'(ren_stall), 1);
        foreach (exp_rel[i]) begin
            check(req, "busy during walk", int'(busy), 1);
            check(req, "release valid", int'(rel_valid), 1);
            check(req, "released phys", int'(rel_phys), exp_rel[i]);
            @(negedge clk);
            ren_valid = 1'b0;
            #1;
        end
        ren_valid = 1'b0;
        check("R9", "busy on final cycle", int'(busy), 1);
        check("R9", "no release on final cycle", int'(rel_valid), 0);
        tick();
        check("R9", "busy falls", int'(busy), 0);
        check("R9", "no release when idle", int'(rel_valid), 0);
    endtask

    task automatic t_reset();
        for (int a = 0; a < NUM_ARCH; a++) look("R1", a, a, 1);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "release after reset", int'(rel_valid), 0);
    endtask

    task automatic t_rename_and_ready();
        rename_one("R3", 3, 10, 8, 3);
        look("R3", 3, 8, 0);
        wb_valid = 1'b1; wb_phys = PHYS_W'(8);
        @(negedge clk); wb_valid = 1'b0; #1;
        look("R2", 3, 8, 1);
        rename_one("R3", 3, 11, 9, 8);
        rename_one("R3", 5, 12, 10, 5);
        // R10: no destination, nothing taken
        ren_valid = 1'b1; ren_has_dst = 1'b0; ren_arch = 3'd6; ren_seq = 8'd13;
        #1;
        check("R10", "no-dst rename stall", int'(ren_stall), 0);
        @(negedge clk); ren_valid = 1'b0; #1;
        look("R10", 6, 6, 1);
        rename_one("R10", 1, 14, 11, 1);
    endtask

    task automatic t_squash_partial();
        sq_valid = 1'b1; sq_seq = 8'd11;
        exp_rel = {}; exp_rel.push_back(11); exp_rel.push_back(10);
        run_walk("R5");
        look("R5", 1, 1, 1);
        look("R5", 5, 5, 1);
        look("R5", 3, 9, 0);
        rename_one("R5", 2, 20, 10, 2);
    endtask

    task automatic t_commit_rules();
        sq_valid = 1'b1; sq_seq = 8'd100;
        cm_valid = 1'b1; cm_seq = 8'd11;
        exp_rel = {};
        run_walk("R8");
        cm_valid = 1'b1; cm_seq = 8'd11;
        exp_rel = {}; exp_rel.push_back(3); exp_rel.push_back(8);
        run_walk("R6");
        look("R6", 3, 9, 0);
        cm_valid = 1'b1; cm_seq = 8'd15;
        exp_rel = {};
        run_walk("R7");
        cm_valid = 1'b1; cm_seq = 8'd20;
        exp_rel = {}; exp_rel.push_back(2);
        run_walk("R6");
        look("R6", 2, 10, 0);
        cm_valid = 1'b1; cm_seq = 8'd50;
        exp_rel = {};
        run_walk("R7");
    endtask

    task automatic t_exhaust_and_unwind();
        int phys_order[8] = '{2, 3, 8, 11, 12, 13, 14, 15};
        int prev_order[8] = '{0, 1, 10, 9, 4, 5, 6, 7};
        for (int a = 0; a < 8; a++) rename_one("R3", a, 30 + a, phys_order[a], prev_order[a]);
        ren_valid = 1'b1; ren_has_dst = 1'b1; ren_arch = '0; ren_seq = 8'd40;
        #1;
        check("R4", "stall with empty pool", int'(ren_stall), 1);
        @(negedge clk); ren_valid = 1'b0; #1;
        look("R4", 0, 2, 0);
        sq_valid = 1'b1; sq_seq = 8'd0;
        exp_rel = {};
        for (int a = 7; a >= 0; a--) exp_rel.push_back(phys_order[a]);
        run_walk("R5");
        look("R5", 0, 0, 1);
        look("R5", 2, 10, 0);
        look("R5", 3, 9, 0);
        look("R5", 7, 7, 1);
    endtask

    initial begin
        rst = 1'b1; src_arch = '0; wb_valid = 1'b0; wb_phys = '0;
        ren_valid = 1'b0; ren_has_dst = 1'b0; ren_arch = '0; ren_seq = '0;
        sq_valid = 1'b0; sq_seq = '0; cm_valid = 1'b0; cm_seq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_rename_and_ready();
        t_squash_partial();
        t_commit_rules();
        t_exhaust_and_unwind();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule